// File: doc/BRIEF.md
# Word Memory with Mapped I/O Ports

This block is a word-organised data and program store with a handful of low addresses set aside as I/O registers. It holds 4096 words of 16 bits, reached through a 12-bit address, a write data bus, a read data bus and separate read and write strobes. A processor data path connects to it the same way it would connect to plain RAM. Specific low addresses feed board-level I/O: there are two input ports (switches and a 4-bit general input) and four output latches (LEDs, display digit anodes, display segment cathodes, and a 4-bit general output).

Reads are synchronous. The address and read strobe are sampled on a clock edge, and the result appears on the read bus after that edge. It then stays there until the next sampled read. Addresses 0x000 and 0x005 return the zero-extended input port values in place of the stored word. Writes always store the full word in RAM. A write to one of the four output addresses also loads the low bits of the data into that port's latch.

In the address plan, the first eight words are the I/O window. Data words follow up to 0x07F, and program words occupy 0x080 to 0xFFF.

Top module: `mmio_memory`

## Requirements
- R1: The block stores 4096 words of 16 bits. A word written at any address from 0x001 to 0x004 or 0x006 to 0xFFF (for example 0x006, 0x07F, 0x080, 0xFFF) is returned unchanged by a later read of that address.
- R2: A read strobe sampled high on a rising edge makes `rd_data` show the selected value after that edge. On edges where the read strobe is low, `rd_data` holds its previous value.
- R3: A read of address 0x000 returns `{8'h00, sw_in}`, using the value of `sw_in` sampled at that edge, whatever was written to RAM at 0x000.
- R4: A read of address 0x005 returns `{12'h000, gp_in}`, using the value of `gp_in` sampled at that edge.
- R5: A write to address 0x001 loads `wr_data[7:0]` into `led_out`.
- R6: A write to address 0x002 loads `wr_data[3:0]` into `anode_out`. A write to address 0x003 loads `wr_data[7:0]` into `cathode_out`.
- R7: A write to address 0x004 loads `wr_data[3:0]` into `gp_out`.
- R8: While `rst` is high on a clock edge, all four output latches and `rd_data` become zero.
- R9: An output latch changes only on an edge where the write strobe is high and the address is that latch's own address. Reads of those addresses, and writes to other addresses, leave it unchanged.
- R10: A write to an output address 0x001 to 0x004 also stores the full 16-bit word in RAM. A later read of that address returns the full word.
- R11: When the read and write strobes are both high on the same edge and address the same RAM word, the write is stored and `rd_data` shows the word held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Word address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 16 | Registered read data |
| sw_in | input | 8 | Switch input port (address 0x000) |
| gp_in | input | 4 | General input port (address 0x005) |
| led_out | output | 8 | LED output latch (address 0x001) |
| anode_out | output | 4 | Digit anode output latch (address 0x002) |
| cathode_out | output | 8 | Segment cathode output latch (address 0x003) |
| gp_out | output | 4 | General output latch (address 0x004) |

## Verification
On every cycle, the assertions check four things: each output latch loads the right data bits after a matching write and holds otherwise, input port reads come back zero-extended from the sampled port value, and `rd_data` holds still when no read is sampled. What the assertions cannot see is the RAM contents. Only the bench scenarios show that words survive at the edges of the data and program regions, that writes to output addresses also land in RAM, and that a read colliding with a write returns the old word. They also show that both reset and writes elsewhere leave the latches as required.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam int SW_W      = 8;
    localparam int GPI_W     = 4;
    localparam int LED_W     = 8;
    localparam int ANODE_W   = 4;
    localparam int CATHODE_W = 8;
    localparam int GPO_W     = 4;

    localparam logic [ADDR_W-1:0] A_SWITCH  = 12'h000;
    localparam logic [ADDR_W-1:0] A_LED     = 12'h001;
    localparam logic [ADDR_W-1:0] A_ANODE   = 12'h002;
    localparam logic [ADDR_W-1:0] A_CATHODE = 12'h003;
    localparam logic [ADDR_W-1:0] A_GPO     = 12'h004;
    localparam logic [ADDR_W-1:0] A_GPI     = 12'h005;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // Where the registered read data comes from.
    typedef enum logic {
        SRC_RAM  = 1'b0,
        SRC_PORT = 1'b1
    } rd_src_e;

    // Decoded read result, captured at the sampling edge.
    typedef struct packed {
        rd_src_e src;
        word_t   port_word;
    } rd_sel_t;

    function automatic rd_sel_t decode_read(addr_t a, logic [SW_W-1:0] sw,
                                            logic [GPI_W-1:0] gp);
        rd_sel_t r;
        r.src       = SRC_RAM;
        r.port_word = '0;
        if (a == A_SWITCH) begin
            r.src       = SRC_PORT;
            r.port_word = {{(DATA_W-SW_W){1'b0}}, sw};
        end else if (a == A_GPI) begin
            r.src       = SRC_PORT;
            r.port_word = {{(DATA_W-GPI_W){1'b0}}, gp};
        end
        return r;
    endfunction

endpackage

// File: rtl/mmio_ram.sv
module mmio_ram
    import mmio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t addr,
    input  word_t wr_data,
    input  logic  rd_en,
    input  logic  wr_en,
    output word_t ram_q
);

    word_t mem [DEPTH];

    // Storage: every write lands here, including I/O addresses.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    // Registered read buffer: captures the word present before any same-edge write.
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_q <= '0;
        end else if (rd_en) begin
            ram_q <= mem[addr];
        end
    end

endmodule

// File: rtl/mmio_port_reg.sv
module mmio_port_reg
    import mmio_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter addr_t MATCH = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  addr_t            addr,
    input  word_t            wr_data,
    input  logic             wr_en,
    output logic [WIDTH-1:0] q
);

    logic hit;
    assign hit = wr_en && (addr == MATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hit) begin
            q <= wr_data[WIDTH-1:0];
        end
    end

    // Latch loading after a matching write: covers R5, R6 and R7.
    assert_port_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == MATCH) |=> (q == $past(wr_data[WIDTH-1:0])));

    assert_port_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == MATCH) |=> $stable(q));

endmodule

// File: rtl/mmio_rd_path.sv
module mmio_rd_path
    import mmio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  addr_t            addr,
    input  logic             rd_en,
    input  logic [SW_W-1:0]  sw_in,
    input  logic [GPI_W-1:0] gp_in,
    input  word_t            ram_q,
    output word_t            rd_data
);

    rd_sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q.src       <= SRC_PORT;
            sel_q.port_word <= '0;
        end else if (rd_en) begin
            sel_q <= decode_read(addr, sw_in, gp_in);
        end
    end

    assign rd_data = (sel_q.src == SRC_PORT) ? sel_q.port_word : ram_q;

    assert_sw_zext_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_SWITCH) |=> (rd_data == {8'h00, $past(sw_in)}));

    assert_gp_zext_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_GPI) |=> (rd_data == {12'h000, $past(gp_in)}));

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/mmio_memory.sv
module mmio_memory
    import mmio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic                 wr_en,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [SW_W-1:0]      sw_in,
    input  logic [GPI_W-1:0]     gp_in,
    output logic [LED_W-1:0]     led_out,
    output logic [ANODE_W-1:0]   anode_out,
    output logic [CATHODE_W-1:0] cathode_out,
    output logic [GPO_W-1:0]     gp_out
);

    word_t ram_q;

    mmio_ram u_ram (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .ram_q   (ram_q)
    );

    mmio_rd_path u_rd (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .rd_en   (rd_en),
        .sw_in   (sw_in),
        .gp_in   (gp_in),
        .ram_q   (ram_q),
        .rd_data (rd_data)
    );

    mmio_port_reg #(.WIDTH(LED_W), .MATCH(A_LED)) u_led (
        .clk (clk), .rst (rst), .addr (addr), .wr_data (wr_data),
        .wr_en (wr_en), .q (led_out)
    );

    mmio_port_reg #(.WIDTH(ANODE_W), .MATCH(A_ANODE)) u_anode (
        .clk (clk), .rst (rst), .addr (addr), .wr_data (wr_data),
        .wr_en (wr_en), .q (anode_out)
    );

    mmio_port_reg #(.WIDTH(CATHODE_W), .MATCH(A_CATHODE)) u_cathode (
        .clk (clk), .rst (rst), .addr (addr), .wr_data (wr_data),
        .wr_en (wr_en), .q (cathode_out)
    );

    mmio_port_reg #(.WIDTH(GPO_W), .MATCH(A_GPO)) u_gpo (
        .clk (clk), .rst (rst), .addr (addr), .wr_data (wr_data),
        .wr_en (wr_en), .q (gp_out)
    );

endmodule

// File: tb/mmio_memory_tb_top.sv
module mmio_memory_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] rd_data;
    logic [7:0]  sw_in = '0;
    logic [3:0]  gp_in = '0;
    logic [7:0]  led_out;
    logic [3:0]  anode_out;
    logic [7:0]  cathode_out;
    logic [3:0]  gp_out;

    always #5 clk = ~clk;

    mmio_memory dut_i (
        .clk (clk), .rst (rst), .addr (addr), .wr_data (wr_data),
        .rd_en (rd_en), .wr_en (wr_en), .rd_data (rd_data),
        .sw_in (sw_in), .gp_in (gp_in), .led_out (led_out),
        .anode_out (anode_out), .cathode_out (cathode_out), .gp_out (gp_out)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_errors = 0;
    logic mon_pend = 1'b0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one bus cycle; a read pushes its expected word.
    task automatic bus(input logic r, input logic w, input logic [11:0] a,
                       input logic [15:0] d, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wr_data = d;
        if (r) sb_q.push_back('{exp: exp, tag: tag});
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) mon_pend <= rd_en && !rst;

    always @(negedge clk) begin
        if (mon_pend) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", rd_data, 16'hxxxx);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 led reset", {8'h0, led_out}, 16'h0);
        check("R8 anode reset", {12'h0, anode_out}, 16'h0);
        check("R8 cathode reset", {8'h0, cathode_out}, 16'h0);
        check("R8 gp_out reset", {12'h0, gp_out}, 16'h0);
        check("R8 rd_data reset", rd_data, 16'h0);
        rst = 1'b0;

        // R1: preload and read back across regions
        bus(0, 1, 12'h006, 16'h0F0F, 16'h0, "");
        bus(0, 1, 12'h010, 16'h1234, 16'h0, "");
        bus(0, 1, 12'h07F, 16'h8001, 16'h0, "");
        bus(0, 1, 12'h080, 16'hBEEF, 16'h0, "");
        bus(0, 1, 12'hFFF, 16'h5A5A, 16'h0, "");
        bus(1, 0, 12'h010, 16'h0, 16'h1234, "R1 read 0x010");
        bus(1, 0, 12'h07F, 16'h0, 16'h8001, "R1 read 0x07F");
        bus(1, 0, 12'h080, 16'h0, 16'hBEEF, "R1 read 0x080");
        bus(1, 0, 12'hFFF, 16'h0, 16'h5A5A, "R1 read 0xFFF");
        bus(1, 0, 12'h006, 16'h0, 16'h0F0F, "R1 read 0x006");
        idle();
        // R2: data holds with no read strobe
        idle(); idle();
        check("R2 rd_data hold", rd_data, 16'h0F0F);

        // R3: switch port, including after a RAM write to 0x000
        sw_in = 8'hA5;
        bus(1, 0, 12'h000, 16'h0, 16'h00A5, "R3 switch A5");
        bus(0, 1, 12'h000, 16'hFFFF, 16'h0, "");
        sw_in = 8'h3C;
        bus(1, 0, 12'h000, 16'h0, 16'h003C, "R3 switch 3C over RAM");
        // R4: general input port
        gp_in = 4'hB;
        bus(1, 0, 12'h005, 16'h0, 16'h000B, "R4 gp_in B");
        idle();

        // R5 and R10
        bus(0, 1, 12'h001, 16'hABCD, 16'h0, "");
        idle();
        check("R5 led", {8'h0, led_out}, 16'h00CD);
        bus(1, 0, 12'h001, 16'h0, 16'hABCD, "R10 RAM word at 0x001");
        // R6
        bus(0, 1, 12'h002, 16'h1237, 16'h0, "");
        bus(0, 1, 12'h003, 16'h00E1, 16'h0, "");
        idle();
        check("R6 anode", {12'h0, anode_out}, 16'h0007);
        check("R6 cathode", {8'h0, cathode_out}, 16'h00E1);
        // R7 and R10
        bus(0, 1, 12'h004, 16'hFFF9, 16'h0, "");
        idle();
        check("R7 gp_out", {12'h0, gp_out}, 16'h0009);
        bus(1, 0, 12'h004, 16'h0, 16'hFFF9, "R10 RAM word at 0x004");

        // R9: read of the port address and a write elsewhere leave latches alone
        bus(1, 0, 12'h001, 16'h0, 16'hABCD, "R9 read 0x001");
        bus(0, 1, 12'h010, 16'h0055, 16'h0, "");
        bus(0, 0, 12'h004, 16'h1111, 16'h0, "");
        idle();
        check("R9 led unchanged", {8'h0, led_out}, 16'h00CD);
        check("R9 gp_out unchanged", {12'h0, gp_out}, 16'h0009);

        // R11: read and write on the same edge
        bus(1, 1, 12'h010, 16'h7777, 16'h0055, "R11 old word on collision");
        bus(1, 0, 12'h010, 16'h0, 16'h7777, "R11 new word after");
        idle();

        // R8: mid-run reset clears latches
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 led after reset", {8'h0, led_out}, 16'h0);
        check("R8 gp_out after reset", {12'h0, gp_out}, 16'h0);
        check("R8 rd_data after reset", rd_data, 16'h0);

        idle(); idle();
        if (sb_q.size() != 0) check("scoreboard drain", 16'(sb_q.size()), 16'h0);
        done = 1'b1;
        finish_run();
    end

endmodule